// File: doc/BRIEF.md
# Gray-Level Window Discriminator Bank

This block classifies one unsigned detector sample per clock against a set of amplitude windows. Five fixed windows sit end to end across the whole black-to-white code range. Each one shares its edge values with its neighbours, so together they cover every code. A sixth window has its own programmable lower and upper limit. Its hit flag is always driven onto a one-bit gate output, which an external area counter uses to measure how long the scan spends inside that band.

A two-bit function select sets what reaches the display output:
- the unmodified sample;
- the OR of whichever fixed windows are enabled;
- the variable window.

A window result is turned into a full-white or full-black display code. All limits are register values loaded through a small write port. The variable window's effective lower limit is clamped so that it never rises above the upper limit, so an illegal window cannot occur.

Top module: `gray_window_bank`

## Requirements
- R1: A window reports a hit when lo <= sample <= hi, with both limits included, and no hit otherwise.
- R2: Six ascending boundary registers B0..B5 define the fixed windows. Window k spans [Bk, Bk+1], so a sample equal to a shared boundary hits both neighbouring windows.
- R3: Reset loads Bk = floor(255*k/5), giving 0, 51, 102, 153, 204 and 255. Reset also sets the variable window to lo=0 and hi=255 and drives both outputs to 0.
- R4: In fixed mode the result is the OR of the fixed hits masked by win_en_i, where bit k enables window k.
- R5: When the programmed variable lower limit exceeds the upper limit, the effective lower limit equals the upper limit.
- R6: gate_o follows the variable window hit regardless of the function select.
- R7: Function select encoding: 0 passes the raw sample, 1 selects the fixed-window result, 2 selects the variable-window result, and 3 passes the raw sample.
- R8: In either window mode a result of 1 gives display code 255 (white) and a result of 0 gives display code 0 (black).
- R9: Both outputs are registered. A sample presented before a clock edge appears on the outputs after that edge.
- R10: A write with cfg_we_i high stores cfg_data_i at the register selected by cfg_addr_i: 0..5 to B0..B5, 6 to the variable lower limit and 7 to the variable upper limit. The new value applies from the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 8 | Detector sample |
| win_en_i | input | 5 | Fixed-window enable mask |
| fsel_i | input | 2 | Function select |
| cfg_we_i | input | 1 | Limit register write strobe |
| cfg_addr_i | input | 3 | Limit register address |
| cfg_data_i | input | 8 | Limit register write value |
| disp_o | output | 8 | Display code |
| gate_o | output | 1 | Area-counter gate |

## Verification
The bench probes samples that sit exactly on a shared fixed boundary, where a design using half-open intervals would light only one of the two windows. It probes samples one code outside each variable limit, where an off-by-one comparison would open the gate too early or close it too late. It programs an inverted variable window to check the clamp; without the clamp the gate would never open, while with it the gate opens on exactly one code. It also reprograms a boundary and then resets, to show that a reset which failed to restore the defaults would leave the moved edge in place.

// File: rtl/gwb_pkg.sv
package gwb_pkg;
  typedef enum logic [1:0] {
    SEL_RAW  = 2'd0,
    SEL_FIX  = 2'd1,
    SEL_VAR  = 2'd2,
    SEL_RAW2 = 2'd3
  } sel_e;

  // evenly spaced default edge k of n across a dw-bit full scale
  function automatic int dflt_bnd(input int k, input int dw, input int n);
    return (((2 ** dw) - 1) * k) / n;
  endfunction
endpackage

// File: rtl/gwb_limit_regs.sv
module gwb_limit_regs
  import gwb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NFIX = 5,
  parameter int AW   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we_i,
  input  logic [AW-1:0]            cfg_addr_i,
  input  logic [DW-1:0]            cfg_data_i,
  output logic [NFIX:0][DW-1:0]    bnd_o,
  output logic [DW-1:0]            var_lo_o,
  output logic [DW-1:0]            var_hi_o
);
  localparam logic [AW-1:0] VLO_ADDR = AW'(NFIX + 1);
  localparam logic [AW-1:0] VHI_ADDR = AW'(NFIX + 2);

  logic [NFIX:0][DW-1:0] bnd_q;
  logic [DW-1:0]         vlo_q, vhi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= NFIX; k++) bnd_q[k] <= DW'(dflt_bnd(k, DW, NFIX));
      vlo_q <= '0;
      vhi_q <= '1;
    end else if (cfg_we_i) begin
      for (int k = 0; k <= NFIX; k++)
        if (cfg_addr_i == AW'(k)) bnd_q[k] <= cfg_data_i;
      if (cfg_addr_i == VLO_ADDR) vlo_q <= cfg_data_i;
      if (cfg_addr_i == VHI_ADDR) vhi_q <= cfg_data_i;
    end
  end

  assign bnd_o    = bnd_q;
  assign var_hi_o = vhi_q;
  // R5: lower limit never allowed above the upper one
  assign var_lo_o = (vlo_q > vhi_q) ? vhi_q : vlo_q;

  a_r5_lo_not_above_hi: assert property (@(posedge clk) disable iff (rst)
    var_lo_o <= var_hi_o);
endmodule

// File: rtl/gwb_window.sv
module gwb_window #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          hit_o
);
  // R1: closed interval
  assign hit_o = (smp_i >= lo_i) && (smp_i <= hi_i);
endmodule

// File: rtl/gwb_route.sv
module gwb_route
  import gwb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NFIX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   smp_i,
  input  sel_e            sel_i,
  input  logic [NFIX-1:0] en_i,
  input  logic [NFIX-1:0] fix_hit_i,
  input  logic            var_hit_i,
  output logic [DW-1:0]   disp_o,
  output logic            gate_o
);
  logic          any_fix, res;
  logic [DW-1:0] disp_d, disp_q;
  logic          gate_q, past_ok;

  always_comb begin
    any_fix = |(fix_hit_i & en_i);
    res     = (sel_i == SEL_FIX) ? any_fix : var_hit_i;
    if (sel_i == SEL_RAW || sel_i == SEL_RAW2) disp_d = smp_i;
    else                                       disp_d = {DW{res}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q  <= '0;
      gate_q  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      disp_q  <= disp_d;
      gate_q  <= var_hit_i;
      past_ok <= 1'b1;
    end
  end

  assign disp_o = disp_q;
  assign gate_o = gate_q;

  a_r9_raw_latency: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(sel_i) == SEL_RAW) |-> disp_o == $past(smp_i));
  a_r8_two_levels: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(sel_i) != SEL_RAW && $past(sel_i) != SEL_RAW2)
      |-> (disp_o == '0 || disp_o == '1));
  a_r4_masked_black: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(sel_i) == SEL_FIX && $past(fix_hit_i & en_i) == '0)
      |-> disp_o == '0);
  a_r6_gate_follow: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> gate_o == $past(var_hit_i));
endmodule

// File: rtl/gray_window_bank.sv
module gray_window_bank
  import gwb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NFIX = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DW-1:0]                 smp_i,
  input  logic [NFIX-1:0]               win_en_i,
  input  logic [1:0]                    fsel_i,
  input  logic                          cfg_we_i,
  input  logic [$clog2(NFIX+3)-1:0]     cfg_addr_i,
  input  logic [DW-1:0]                 cfg_data_i,
  output logic [DW-1:0]                 disp_o,
  output logic                          gate_o
);
  localparam int AW = $clog2(NFIX + 3);

  logic [NFIX:0][DW-1:0] bnd;
  logic [DW-1:0]         var_lo, var_hi;
  logic [NFIX-1:0]       fix_hit;
  logic                  var_hit;

  gwb_limit_regs #(.DW(DW), .NFIX(NFIX), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_data_i (cfg_data_i),
    .bnd_o      (bnd),
    .var_lo_o   (var_lo),
    .var_hi_o   (var_hi)
  );

  // R2: window k uses edges k and k+1, shared with its neighbours
  for (genvar k = 0; k < NFIX; k++) begin : g_fix
    gwb_window #(.DW(DW)) u_win (
      .smp_i (smp_i),
      .lo_i  (bnd[k]),
      .hi_i  (bnd[k+1]),
      .hit_o (fix_hit[k])
    );
  end

  gwb_window #(.DW(DW)) u_var (
    .smp_i (smp_i),
    .lo_i  (var_lo),
    .hi_i  (var_hi),
    .hit_o (var_hit)
  );

  gwb_route #(.DW(DW), .NFIX(NFIX)) u_route (
    .clk       (clk),
    .rst       (rst),
    .smp_i     (smp_i),
    .sel_i     (sel_e'(fsel_i)),
    .en_i      (win_en_i),
    .fix_hit_i (fix_hit),
    .var_hit_i (var_hit),
    .disp_o    (disp_o),
    .gate_o    (gate_o)
  );
endmodule

// File: tb/tb_gray_window_bank.sv
module tb_gray_window_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] smp = '0;
  logic [4:0] en = '0;
  logic [1:0] fsel = '0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] disp;
  logic       gate;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gray_window_bank dut (
    .clk(clk), .rst(rst), .smp_i(smp), .win_en_i(en), .fsel_i(fsel),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(data),
    .disp_o(disp), .gate_o(gate)
  );

  // {sample, enable, select, expected display, expected gate}; variable window 100..150
  localparam int NV = 18;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {8'd37,  5'b00001, 2'd0, 8'd37,  1'b0},  // R7 raw
    {8'd37,  5'b00001, 2'd1, 8'd255, 1'b0},  // R4 R8
    {8'd37,  5'b00010, 2'd1, 8'd0,   1'b0},  // R4 masked
    {8'd51,  5'b00010, 2'd1, 8'd255, 1'b0},  // R2 shared edge upper
    {8'd51,  5'b00001, 2'd1, 8'd255, 1'b0},  // R2 shared edge lower
    {8'd52,  5'b00001, 2'd1, 8'd0,   1'b0},  // R1 just outside
    {8'd120, 5'b00100, 2'd1, 8'd255, 1'b1},  // R4
    {8'd120, 5'b00000, 2'd2, 8'd255, 1'b1},  // R7 var
    {8'd99,  5'b11111, 2'd2, 8'd0,   1'b0},  // R1 below var lo
    {8'd100, 5'b00000, 2'd2, 8'd255, 1'b1},  // R1 at var lo
    {8'd150, 5'b00000, 2'd2, 8'd255, 1'b1},  // R1 at var hi
    {8'd151, 5'b00000, 2'd2, 8'd0,   1'b0},  // R1 above var hi
    {8'd255, 5'b10000, 2'd1, 8'd255, 1'b0},  // R3 white edge
    {8'd255, 5'b01111, 2'd1, 8'd0,   1'b0},  // R4
    {8'd200, 5'b11010, 2'd1, 8'd255, 1'b0},  // R4 combined
    {8'd0,   5'b00001, 2'd1, 8'd255, 1'b0},  // R3 black edge
    {8'd77,  5'b11111, 2'd3, 8'd77,  1'b0},  // R7 code 3 raw
    {8'd130, 5'b00000, 2'd0, 8'd130, 1'b1}   // R6 gate in raw mode
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; data = d;
    @(negedge clk); we = 1'b0;
  endtask

  // R9: drive, one edge, sample
  task automatic step(input logic [7:0] s, input logic [4:0] e, input logic [1:0] f);
    @(negedge clk); smp = s; en = e; fsel = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset disp", disp, 0);
    chk("R3 reset gate", gate, 0);
    rst = 1'b0;
    wr(3'd6, 8'd100);
    wr(3'd7, 8'd150);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:16], VEC[i][15:11], VEC[i][10:9]);
      chk($sformatf("R1/R9 vec%0d disp", i), disp, VEC[i][8:1]);
      chk($sformatf("R6 vec%0d gate", i), gate, VEC[i][0]);
    end
    // R5 clamp: lo=200 above hi=150 collapses to [150,150]
    wr(3'd6, 8'd200);
    step(8'd150, 5'b0, 2'd2);
    chk("R5 clamp at hi disp", disp, 255);
    chk("R5 clamp at hi gate", gate, 1);
    step(8'd149, 5'b0, 2'd2);
    chk("R5 clamp below", gate, 0);
    step(8'd151, 5'b0, 2'd2);
    chk("R5 clamp above", gate, 0);
    // R10 boundary rewrite: B1=60
    wr(3'd1, 8'd60);
    step(8'd55, 5'b00001, 2'd1);
    chk("R10 moved edge w0", disp, 255);
    step(8'd55, 5'b00010, 2'd1);
    chk("R10 moved edge w1", disp, 0);
    step(8'd60, 5'b00010, 2'd1);
    chk("R2 new shared edge", disp, 255);
    // R3 defaults restored by reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 reset clears disp", disp, 0);
    rst = 1'b0;
    step(8'd55, 5'b00001, 2'd1);
    chk("R3 default B1 restored", disp, 0);
    chk("R3 default var window open", gate, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule